// File: doc/BRIEF.md
# Head Step and Load Timer

This block produces the timing for head movement and head loading on a floppy-style disk drive port. A configuration write sets three 4-bit timing codes: the step spacing, the head-unload delay and the head-load settle delay. The same write carries a transfer-mode bit. That bit must select the DMA transfer mode. A write that asks for the unsupported non-DMA mode is refused and flagged.

A seek request with a step count makes the block emit that many single-clock step pulses. The interval from the request to the first pulse is about half the normal spacing. After the last pulse a done strobe follows. A head-load request raises the head-load line at once and signals read/write readiness after the load delay. When a read/write execution phase ends, the head-load line is dropped after the unload delay. A new load request in the meantime cancels that countdown.

All delays are counted in ticks. The length of a tick follows a 2-bit data-rate select. The timing is the same for MFM and FM recording.

Top module: `head_step_timer`

## Requirements
- R1: After reset, step_out, seek_done, rw_ready, cfg_err and head_load are low, and all three timing codes are 0.
- R2: One tick lasts 8 × 2^rate_sel clocks. rate_sel is sampled when a countdown is loaded.
- R3: Between later step pulses of one seek, the spacing is (16 − S) ticks, where S is the 4-bit step code.
- R4: Counting from the clock edge that samples seek_go, the first step pulse is high in the cycle after ceil((16 − S)/2) ticks.
- R5: A seek with count N > 0 emits exactly N step pulses, and each pulse is one clock wide.
- R6: seek_done pulses for one clock, one cycle after the last step pulse. A seek with count 0 gives seek_done in the cycle right after the request and no step pulse.
- R7: load_go sets head_load from the next cycle. rw_ready pulses L ticks after the load_go edge, where L is the load code and code 0 means 16.
- R8: exec_end makes head_load fall U ticks after the exec_end edge, where U is the unload code and code 0 means 16.
- R9: A load_go while an unload countdown is pending cancels that countdown, so head_load stays high.
- R10: A configuration write with cfg_nodma = 1 changes no timing code and pulses cfg_err in the next cycle. A write with cfg_nodma = 0 stores the codes and leaves cfg_err low.
- R11: A seek_go that arrives while a seek is still in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Data-rate code; 0 is the fastest time base |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_step | input | 4 | Step spacing code S |
| cfg_unload | input | 4 | Head-unload code U |
| cfg_load | input | 4 | Head-load code L |
| cfg_nodma | input | 1 | Transfer-mode bit; must be 0 |
| cfg_err | output | 1 | One-cycle pulse for a refused non-DMA write |
| seek_go | input | 1 | Seek request strobe |
| seek_count | input | 8 | Number of step pulses for the seek |
| step_out | output | 1 | Step pulse |
| seek_done | output | 1 | Pulse after the final step |
| load_go | input | 1 | Head-load request strobe |
| exec_end | input | 1 | End of a read/write execution phase |
| head_load | output | 1 | Head-load line |
| rw_ready | output | 1 | Pulse when the head has settled |

## Verification
Seeks are run with step codes 0, 5 and 15 at several rates. The code-15 case separates the round-up of the first interval from plain halving, and a change of rate shows whether the time base doubles per code. Seek counts of 0, 1, 2 and 3 separate the first interval from the later spacing and check where the done strobe falls. A refused configuration write is followed by a seek that still shows the old spacing, and a second seek_go is issued in the middle of a seek. Load, unload and cancel sequences, including an unload code of 0, check the head-load line and the ready strobe.

// File: rtl/hst_pkg.sv
package hst_pkg;
  localparam int FIELD_W   = 4;
  localparam int RATE_W    = 2;
  localparam int TICK_BASE = 8;
  localparam int TICK_SH   = $clog2(TICK_BASE);
  localparam int CNT_W     = TICK_SH + (2**RATE_W - 1) + FIELD_W + 1;

  typedef logic [CNT_W-1:0]   clk_cnt_t;
  typedef logic [FIELD_W-1:0] code_t;
  typedef logic [RATE_W-1:0]  rate_t;

  // ticks to clocks: a tick is TICK_BASE << rate clocks
  function automatic clk_cnt_t ticks_to_clk(clk_cnt_t ticks, rate_t r);
    return ticks << (TICK_SH + int'(r));
  endfunction

  function automatic clk_cnt_t step_ticks(code_t v);
    return clk_cnt_t'(2**FIELD_W) - clk_cnt_t'(v);
  endfunction

  function automatic clk_cnt_t first_ticks(code_t v);
    return (step_ticks(v) + clk_cnt_t'(1)) >> 1;
  endfunction

  // hold delays: code 0 stands for the full range
  function automatic clk_cnt_t hold_ticks(code_t v);
    return (v == '0) ? clk_cnt_t'(2**FIELD_W) : clk_cnt_t'(v);
  endfunction
endpackage

// File: rtl/hst_step_gen.sv
module hst_step_gen
  import hst_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rate_t              rate_sel,
  input  code_t              step_code,
  input  logic               seek_go,
  input  logic [COUNT_W-1:0] seek_count,
  output logic               step_out,
  output logic               seek_done
);
  clk_cnt_t           cnt;
  logic [COUNT_W-1:0] left;
  logic               busy;
  logic               last_q;

  wire      fire      = busy && (cnt == clk_cnt_t'(1));
  wire      start     = seek_go && !busy;
  clk_cnt_t first_clk;
  clk_cnt_t intv_clk;

  assign first_clk = ticks_to_clk(first_ticks(step_code), rate_sel);
  assign intv_clk  = ticks_to_clk(step_ticks(step_code), rate_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      left      <= '0;
      busy      <= 1'b0;
      last_q    <= 1'b0;
      step_out  <= 1'b0;
      seek_done <= 1'b0;
    end else begin
      step_out  <= fire;
      seek_done <= last_q;
      last_q    <= 1'b0;
      if (start) begin
        if (seek_count == '0) begin
          seek_done <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= first_clk;
          left <= seek_count;
        end
      end else if (busy) begin
        if (fire) begin
          if (left == COUNT_W'(1)) begin
            busy   <= 1'b0;
            cnt    <= '0;
            last_q <= 1'b1;
          end else begin
            cnt  <= intv_clk;
            left <= left - COUNT_W'(1);
          end
        end else begin
          cnt <= cnt - clk_cnt_t'(1);
        end
      end
    end
  end

  // R5
  step_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_out |=> !step_out);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seek_done |-> !busy);

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> (left == $past(left)));
endmodule

// File: rtl/hst_head_ctl.sv
module hst_head_ctl
  import hst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  rate_t rate_sel,
  input  code_t load_code,
  input  code_t unload_code,
  input  logic  load_go,
  input  logic  exec_end,
  output logic  head_load,
  output logic  rw_ready
);
  clk_cnt_t load_cnt;
  clk_cnt_t unload_cnt;
  clk_cnt_t load_clk;
  clk_cnt_t unload_clk;

  assign load_clk   = ticks_to_clk(hold_ticks(load_code), rate_sel);
  assign unload_clk = ticks_to_clk(hold_ticks(unload_code), rate_sel);

  wire unload_expire = (unload_cnt == clk_cnt_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_cnt   <= '0;
      unload_cnt <= '0;
      head_load  <= 1'b0;
      rw_ready   <= 1'b0;
    end else begin
      rw_ready <= 1'b0;
      if (load_go) begin
        head_load  <= 1'b1;
        load_cnt   <= load_clk;
        unload_cnt <= '0;
      end else begin
        if (load_cnt != '0) begin
          if (load_cnt == clk_cnt_t'(1)) rw_ready <= 1'b1;
          load_cnt <= load_cnt - clk_cnt_t'(1);
        end
        if (exec_end) begin
          unload_cnt <= unload_clk;
        end else if (unload_cnt != '0) begin
          unload_cnt <= unload_cnt - clk_cnt_t'(1);
          if (unload_expire) begin
            head_load <= 1'b0;
            load_cnt  <= '0;
            rw_ready  <= 1'b0;
          end
        end
      end
    end
  end

  // R7
  ready_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw_ready |-> head_load);

  // R7
  load_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> head_load);

  // R8
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(head_load) |-> $past(unload_expire));
endmodule

// File: rtl/head_step_timer.sv
module head_step_timer
  import hst_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic               cfg_we,
  input  logic [FIELD_W-1:0] cfg_step,
  input  logic [FIELD_W-1:0] cfg_unload,
  input  logic [FIELD_W-1:0] cfg_load,
  input  logic               cfg_nodma,
  output logic               cfg_err,
  input  logic               seek_go,
  input  logic [COUNT_W-1:0] seek_count,
  output logic               step_out,
  output logic               seek_done,
  input  logic               load_go,
  input  logic               exec_end,
  output logic               head_load,
  output logic               rw_ready
);
  code_t step_q, unload_q, load_q;

  wire cfg_accept = cfg_we && !cfg_nodma;
  wire cfg_refuse = cfg_we && cfg_nodma;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= '0;
      unload_q <= '0;
      load_q   <= '0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= cfg_refuse;
      if (cfg_accept) begin
        step_q   <= cfg_step;
        unload_q <= cfg_unload;
        load_q   <= cfg_load;
      end
    end
  end

  hst_step_gen #(.COUNT_W(COUNT_W)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .step_code (step_q),
    .seek_go   (seek_go),
    .seek_count(seek_count),
    .step_out  (step_out),
    .seek_done (seek_done)
  );

  hst_head_ctl u_head (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .load_code  (load_q),
    .unload_code(unload_q),
    .load_go    (load_go),
    .exec_end   (exec_end),
    .head_load  (head_load),
    .rw_ready   (rw_ready)
  );

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we && cfg_nodma));

  // R10
  refused_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($stable(step_q) && $stable(load_q) && $stable(unload_q)));
endmodule

// File: tb/sim_head_step_timer.sv
module sim_head_step_timer;
  localparam int EV_STEP = 0, EV_DONE = 1, EV_RDY = 2, EV_FALL = 3;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } ev_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rate_sel = '0;
  logic       cfg_we = 0, cfg_nodma = 0;
  logic [3:0] cfg_step = '0, cfg_unload = '0, cfg_load = '0;
  logic       seek_go = 0, load_go = 0, exec_end = 0;
  logic [7:0] seek_count = '0;
  logic       cfg_err, step_out, seek_done, head_load, rw_ready;

  int  cyc = 0, n_chk = 0, n_fail = 0;
  int  m_step = 0, m_unload = 0, m_load = 0;
  ev_t exp_q[$];
  logic prev_hl = 1'b0;
  bit   done_flag = 0;

  head_step_timer u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .cfg_we(cfg_we), .cfg_step(cfg_step), .cfg_unload(cfg_unload),
    .cfg_load(cfg_load), .cfg_nodma(cfg_nodma), .cfg_err(cfg_err),
    .seek_go(seek_go), .seek_count(seek_count), .step_out(step_out),
    .seek_done(seek_done), .load_go(load_go), .exec_end(exec_end),
    .head_load(head_load), .rw_ready(rw_ready)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic void push(int k, int c, string r);
    ev_t e;
    e.kind = k; e.cyc = c; e.req = r;
    exp_q.push_back(e);
  endfunction

  function automatic int tick_clk() ;
    return 8 * (2 ** int'(rate_sel));
  endfunction

  function automatic int hold_of(int v);
    return (v == 0) ? 16 : v;
  endfunction

  // monitor: pops one expected item per observed event
  task automatic observe(int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(0, "R5/R6/R8/R11 unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.req, kind, e.kind);
      check(e.cyc == cyc, e.req, cyc, e.cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (step_out)  observe(EV_STEP);
      if (seek_done) observe(EV_DONE);
      if (rw_ready)  observe(EV_RDY);
      if (prev_hl && !head_load) observe(EV_FALL);
    end
    prev_hl <= head_load;
  end

  task automatic cfg(int s, int u, int l, bit nd);
    @(negedge clk);
    cfg_we = 1; cfg_step = 4'(s); cfg_unload = 4'(u); cfg_load = 4'(l); cfg_nodma = nd;
    @(negedge clk);
    cfg_we = 0; cfg_nodma = 0;
    check(cfg_err == nd, "R10 cfg_err", int'(cfg_err), int'(nd));
    if (!nd) begin m_step = s; m_unload = u; m_load = l; end
  endtask

  // driver: requests a seek and queues expected step/done cycles
  task automatic do_seek(int n);
    int c, b, f, iv;
    @(negedge clk);
    c  = cyc;
    b  = tick_clk();
    f  = ((16 - m_step + 1) / 2) * b;
    iv = (16 - m_step) * b;
    seek_go = 1; seek_count = 8'(n);
    if (n == 0) push(EV_DONE, c + 1, "R6 zero-count done");
    for (int k = 1; k <= n; k++)
      push(EV_STEP, c + 1 + f + (k - 1) * iv, (k == 1) ? "R4 first step" : "R3 step spacing");
    if (n > 0) push(EV_DONE, c + 2 + f + (n - 1) * iv, "R6 done after last step");
    @(negedge clk);
    seek_go = 0;
  endtask

  task automatic settle();
    wait (exp_q.size() == 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check(!step_out && !seek_done && !rw_ready && !cfg_err && !head_load,
          "R1 reset outputs", int'({step_out, seek_done, rw_ready, cfg_err, head_load}), 0);

    // R1 default code 0 gives spacing 16 ticks, R2 rate 0
    do_seek(2); settle();

    cfg(5, 3, 2, 0);
    do_seek(3); settle();        // R3 R4 R5: first 6 ticks, then 11

    rate_sel = 2'd3;             // R2: tick 64 clocks
    cfg(15, 3, 2, 0);
    do_seek(2); settle();        // R4 round up: ceil(1/2)=1

    rate_sel = 2'd1;
    do_seek(0); settle();        // R6 count 0
    do_seek(1); settle();        // R6 single step

    rate_sel = 2'd0;
    cfg(5, 3, 2, 0);
    cfg(2, 9, 9, 1);             // R10 refused write keeps code 5
    do_seek(2); settle();

    // R11: second request mid-seek is ignored
    do_seek(3);
    repeat (20) @(negedge clk);
    seek_go = 1; seek_count = 8'd7;
    @(negedge clk);
    seek_go = 0;
    settle();

    // R7 load and ready
    @(negedge clk);
    c = cyc; load_go = 1;
    push(EV_RDY, c + 1 + hold_of(m_load) * tick_clk(), "R7 ready delay");
    @(negedge clk);
    load_go = 0;
    check(head_load == 1, "R7 head_load rise", int'(head_load), 1);
    settle();

    // R8 unload
    @(negedge clk);
    c = cyc; exec_end = 1;
    push(EV_FALL, c + 1 + hold_of(m_unload) * tick_clk(), "R8 unload delay");
    @(negedge clk);
    exec_end = 0;
    settle();

    // R9 cancel pending unload
    @(negedge clk);
    load_go = 1;
    push(EV_RDY, cyc + 1 + hold_of(m_load) * tick_clk(), "R9 reload ready");
    @(negedge clk);
    load_go = 0;
    settle();
    @(negedge clk);
    exec_end = 1;
    @(negedge clk);
    exec_end = 0;
    repeat (9) @(negedge clk);
    c = cyc; load_go = 1;
    push(EV_RDY, c + 1 + hold_of(m_load) * tick_clk(), "R9 ready after cancel");
    @(negedge clk);
    load_go = 0;
    settle();
    repeat (60) @(negedge clk);
    check(head_load == 1, "R9 unload cancelled", int'(head_load), 1);

    // R8 with code 0 meaning 16 ticks, rate 2
    rate_sel = 2'd2;
    cfg(5, 0, 2, 0);
    @(negedge clk);
    c = cyc; exec_end = 1;
    push(EV_FALL, c + 1 + 16 * tick_clk(), "R8 code 0 unload");
    @(negedge clk);
    exec_end = 0;
    settle();
    check(head_load == 0, "R8 head_load low", int'(head_load), 0);

    check(exp_q.size() == 0, "R5 all events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule